// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification Register

This block gathers the interrupt conditions of one serial channel and drives a single interrupt line from them. The other channel logic (receive and transmit queues, line status checks, modem line watchers and flow-control detectors) presents each condition as a level. Each condition is gated by an 8-bit enable register. An identification register then reports the most urgent source that is both enabled and pending, as a fixed code.

Software writes the enable register and reads both registers through a small register port. Reading the identification register produces an acknowledge strobe, along with a one-hot copy of the reported source. Source blocks use this to perform their own clear-on-read.

The transmit-threshold interrupt is held inside this block. It is set when the transmit level falls below its threshold, or when its enable is switched back on while the level is still below the threshold. It is cleared by the identification read that reports it, or by a write to the transmitter. The upper four enable bits are write-protected unless the enhanced-feature input is high.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00 (select 0), the identification register reads 0x01 with fifo_en_i low, and irq_o is low.
- R2: A write to the enable register changes bits 7:4 only when efr_en_i is 1; bits 3:0 are always written. Enable bit roles: 0 receive data and timeout, 1 transmit threshold, 2 line error, 3 modem, 4 sleep (stored only), 5 Xoff/special character, 6 RTS inactive transition, 7 CTS inactive transition.
- R3: irq_o is 1 exactly when at least one enabled source is pending, and identification bit 0 is the inverse of irq_o.
- R4: Identification bits 5:0 report the highest-priority enabled pending source, in this order from highest: line error 0x06, receive timeout 0x0C, receive data 0x04, transmit threshold 0x02, modem 0x00, Xoff/special 0x10, CTS or RTS inactive 0x20.
- R5: Receive timeout and receive data share one enable bit (bit 0), and the timeout is reported when both are pending.
- R6: Identification bits 7:6 both equal fifo_en_i.
- R7: The transmit interrupt becomes pending on the clock edge where tx_below_i is first seen high. It is cleared by an identification read that reports it, or by tx_wr_i; a clear wins over a set in the same cycle.
- R8: A write that sets enable bit 1 from 0 while tx_below_i is high makes the transmit interrupt pending at that edge.
- R9: With no enabled source pending, identification bits 5:1 are zero.
- R10: ack_o is high during an identification read (reg_rd_i with reg_sel_i=1). ack_src_o is then one-hot on the reported source, using bit order 0 line error, 1 timeout, 2 receive data, 3 transmit, 4 modem, 5 Xoff, 6 CTS, 7 RTS. It is zero when no source is pending or when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | 0 = enable register, 1 = identification register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| efr_en_i | input | 1 | Enhanced-feature enable, unlocks enable bits 7:4 |
| fifo_en_i | input | 1 | FIFO-enable control bit, mirrored into identification bits 7:6 |
| rx_err_i | input | 1 | Receive line error pending |
| rx_tmo_i | input | 1 | Receive timeout pending |
| rx_rdy_i | input | 1 | Receive data at or above trigger level |
| tx_below_i | input | 1 | Transmit level below threshold |
| tx_wr_i | input | 1 | Transmitter written |
| modem_i | input | 1 | Modem status change pending |
| xoff_i | input | 1 | Xoff or special character detected |
| cts_rise_i | input | 1 | CTS went inactive |
| rts_rise_i | input | 1 | RTS went inactive |
| irq_o | output | 1 | Interrupt output |
| ack_o | output | 1 | Identification read strobe |
| ack_src_o | output | 8 | One-hot reported source during an identification read |

## Verification
The identification value, irq_o and the acknowledge outputs are combinational. The bench therefore drives the conditions at a falling edge and samples 1 ns later, within the same half cycle. Enable writes and the transmit pending state take effect at the next rising edge, so those results are checked at the falling edge that follows it. The same applies to the clear that follows a reporting read or a transmitter write. The priority sweep steps through all 128 combinations of the level conditions under four enable patterns. Each result is compared with a priority chain written separately in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 8;
  localparam int IE_W = 8;

  // enable bit positions
  localparam int IE_RX   = 0;
  localparam int IE_THR  = 1;
  localparam int IE_LSR  = 2;
  localparam int IE_MDM  = 3;
  localparam int IE_XOFF = 5;
  localparam int IE_RTS  = 6;
  localparam int IE_CTS  = 7;

  // source index = priority rank, 0 highest
  typedef enum logic [2:0] {
    SRC_LERR = 3'd0,
    SRC_RTMO = 3'd1,
    SRC_RDAT = 3'd2,
    SRC_THR  = 3'd3,
    SRC_MDM  = 3'd4,
    SRC_XOFF = 3'd5,
    SRC_CTS  = 3'd6,
    SRC_RTS  = 3'd7
  } src_e;

  // identification bits 5:1 per source
  function automatic logic [4:0] src_id(input int unsigned idx);
    case (idx)
      0:       return 5'b00011;
      1:       return 5'b00110;
      2:       return 5'b00010;
      3:       return 5'b00001;
      4:       return 5'b00000;
      5:       return 5'b01000;
      default: return 5'b10000;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
  parameter int W        = 8,
  parameter int LOCK_LSB = 4,
  parameter int THR_BIT  = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         unlock_i,
  output logic [W-1:0] ie_o,
  output logic         thr_rearm_o
);
  localparam logic [W-1:0] OPEN_MASK = W'((1 << LOCK_LSB) - 1);

  logic [W-1:0] ie_q, wmask;

  assign wmask = unlock_i ? {W{1'b1}} : OPEN_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ie_q <= '0;
    else if (wr_i) ie_q <= (ie_q & ~wmask) | (wdata_i & wmask);
  end

  assign ie_o        = ie_q;
  assign thr_rearm_o = wr_i && wdata_i[THR_BIT] && !ie_q[THR_BIT];
endmodule

// File: rtl/uart_irq_txarm.sv
module uart_irq_txarm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_i,
  input  logic rearm_i,
  input  logic ack_i,
  input  logic tx_wr_i,
  output logic pend_o
);
  logic below_q, pend_q, set_w, clr_w;

  assign set_w = (below_i && !below_q) || (rearm_i && below_i);
  assign clr_w = ack_i || tx_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      below_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      below_q <= below_i;
      if (clr_w)      pend_q <= 1'b0;
      else if (set_w) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o,
  output logic [4:0]   id_o
);
  // lowest index wins
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) id_o = id_o | src_id(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic            reg_sel_i,
  input  logic [IE_W-1:0] reg_wdata_i,
  output logic [IE_W-1:0] reg_rdata_o,
  input  logic            efr_en_i,
  input  logic            fifo_en_i,
  input  logic            rx_err_i,
  input  logic            rx_tmo_i,
  input  logic            rx_rdy_i,
  input  logic            tx_below_i,
  input  logic            tx_wr_i,
  input  logic            modem_i,
  input  logic            xoff_i,
  input  logic            cts_rise_i,
  input  logic            rts_rise_i,
  output logic            irq_o,
  output logic            ack_o,
  output logic [NSRC-1:0] ack_src_o
);
  logic [IE_W-1:0] ie_q;
  logic            rearm, thr_pend, any;
  logic [NSRC-1:0] req, grant;
  logic [4:0]      id;
  logic [IE_W-1:0] ident;

  uart_irq_enable #(.W(IE_W), .LOCK_LSB(4), .THR_BIT(IE_THR)) u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i && !reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .unlock_i   (efr_en_i),
    .ie_o       (ie_q),
    .thr_rearm_o(rearm)
  );

  uart_irq_txarm u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .below_i(tx_below_i),
    .rearm_i(rearm),
    .ack_i  (ack_src_o[SRC_THR]),
    .tx_wr_i(tx_wr_i),
    .pend_o (thr_pend)
  );

  assign req[SRC_LERR] = rx_err_i   && ie_q[IE_LSR];
  assign req[SRC_RTMO] = rx_tmo_i   && ie_q[IE_RX];
  assign req[SRC_RDAT] = rx_rdy_i   && ie_q[IE_RX];
  assign req[SRC_THR]  = thr_pend   && ie_q[IE_THR];
  assign req[SRC_MDM]  = modem_i    && ie_q[IE_MDM];
  assign req[SRC_XOFF] = xoff_i     && ie_q[IE_XOFF];
  assign req[SRC_CTS]  = cts_rise_i && ie_q[IE_CTS];
  assign req[SRC_RTS]  = rts_rise_i && ie_q[IE_RTS];

  uart_irq_prio #(.N(NSRC)) u_prio (
    .req_i  (req),
    .grant_o(grant),
    .any_o  (any),
    .id_o   (id)
  );

  assign ident       = {fifo_en_i, fifo_en_i, id, !any};
  assign reg_rdata_o = reg_sel_i ? ident : ie_q;
  assign irq_o       = any;
  assign ack_o       = reg_rd_i && reg_sel_i;
  assign ack_src_o   = ack_o ? grant : '0;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic       reg_sel_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       efr_en_i,
  input logic       fifo_en_i,
  input logic       rx_err_i,
  input logic       tx_below_i,
  input logic       tx_wr_i,
  input logic       irq_o,
  input logic       ack_o,
  input logic [7:0] ack_src_o,
  input logic [7:0] ie_q,
  input logic       thr_pend
);
  // R2
  upper_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !reg_sel_i && !efr_en_i |=> ie_q[7:4] == $past(ie_q[7:4]));
  // R3
  pend_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> reg_rdata_o[0] == !irq_o);
  // R6
  mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> reg_rdata_o[7:6] == {2{fifo_en_i}});
  // R4
  lerr_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i && rx_err_i && ie_q[2] |-> reg_rdata_o[5:0] == 6'h06);
  // R10
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_src_o));
  // R10
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> ack_src_o == 8'h00);
  // R7
  thr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !thr_pend);
  // R8
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !reg_sel_i && reg_wdata_i[1] && !ie_q[1] && tx_below_i &&
    !tx_wr_i && !(reg_rd_i && reg_sel_i) |=> thr_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_wr_i = 0, reg_rd_i = 0, reg_sel_i = 0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic efr_en_i = 0, fifo_en_i = 0;
  logic rx_err_i = 0, rx_tmo_i = 0, rx_rdy_i = 0, tx_below_i = 0, tx_wr_i = 0;
  logic modem_i = 0, xoff_i = 0, cts_rise_i = 0, rts_rise_i = 0;
  logic irq_o, ack_o;
  logic [7:0] ack_src_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_irq_ident dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_ie(input logic [7:0] d);
    @(negedge clk_i);
    reg_sel_i = 0; reg_wdata_i = d; reg_wr_i = 1;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic peek(input logic sel, output logic [7:0] d);
    reg_sel_i = sel; #1; d = reg_rdata_o;
  endtask

  // c: 0 err,1 tmo,2 rdy,3 modem,4 xoff,5 cts,6 rts
  function automatic logic [7:0] exp_ident(input logic [6:0] c, input logic tx,
                                          input logic [7:0] ie, input logic f);
    logic [5:0] v;
    if      (c[0] && ie[2]) v = 6'h06;
    else if (c[1] && ie[0]) v = 6'h0C;
    else if (c[2] && ie[0]) v = 6'h04;
    else if (tx && ie[1])   v = 6'h02;
    else if (c[3] && ie[3]) v = 6'h00;
    else if (c[4] && ie[5]) v = 6'h10;
    else if ((c[5] && ie[7]) || (c[6] && ie[6])) v = 6'h20;
    else v = 6'h01;
    return {f, f, v};
  endfunction

  function automatic logic [7:0] exp_src(input logic [6:0] c, input logic [7:0] ie);
    if      (c[0] && ie[2]) return 8'h01;
    else if (c[1] && ie[0]) return 8'h02;
    else if (c[2] && ie[0]) return 8'h04;
    else if (c[3] && ie[3]) return 8'h10;
    else if (c[4] && ie[5]) return 8'h20;
    else if (c[5] && ie[7]) return 8'h40;
    else if (c[6] && ie[6]) return 8'h80;
    return 8'h00;
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    logic [7:0] pats [4] = '{8'hFF, 8'h0F, 8'hA5, 8'h5A};
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    peek(0, d); check("R1 enable reset", d, 8'h00);
    peek(1, d); check("R1 ident reset", d, 8'h01);
    check("R1 irq reset", {7'b0, irq_o}, 8'h00);

    // R2 write lock on bits 7:4
    wr_ie(8'hFF); peek(0, d); check("R2 locked write", d, 8'h0F);
    efr_en_i = 1;
    wr_ie(8'hFF); peek(0, d); check("R2 unlocked write", d, 8'hFF);
    efr_en_i = 0;
    wr_ie(8'h00); peek(0, d); check("R2 locked clear", d, 8'hF0);
    efr_en_i = 1;

    // R3 R4 R5 R9 R10 priority sweep
    foreach (pats[p]) begin
      wr_ie(pats[p]);
      for (int c = 0; c < 128; c++) begin
        @(negedge clk_i);
        {rts_rise_i, cts_rise_i, xoff_i, modem_i, rx_rdy_i, rx_tmo_i, rx_err_i} = 7'(c);
        reg_sel_i = 1; reg_rd_i = 1; #1;
        e = exp_ident(7'(c), 1'b0, pats[p], 1'b0);
        check("R4/R5/R9 ident", reg_rdata_o, e);
        check("R3 irq", {7'b0, irq_o}, {7'b0, ~e[0]});
        check("R10 ack source", ack_src_o, exp_src(7'(c), pats[p]));
        check("R10 ack strobe", {7'b0, ack_o}, 8'h01);
        reg_rd_i = 0;
      end
    end
    @(negedge clk_i);
    {rts_rise_i, cts_rise_i, xoff_i, modem_i, rx_rdy_i, rx_tmo_i, rx_err_i} = '0;
    #1 check("R10 no read", ack_src_o, 8'h00);

    // R7 transmit set, read-clear
    wr_ie(8'h02);
    tx_below_i = 1;
    @(negedge clk_i);
    peek(1, d); check("R7 tx set", d, 8'h02);
    reg_rd_i = 1; #1;
    check("R7 tx ack source", ack_src_o, 8'h08);
    @(negedge clk_i); reg_rd_i = 0;
    peek(1, d); check("R7 tx read clear", d, 8'h01);
    @(negedge clk_i);
    peek(1, d); check("R7 level held no reset", d, 8'h01);

    // R8 re-enable re-arms
    wr_ie(8'h00);
    wr_ie(8'h02);
    peek(1, d); check("R8 rearm", d, 8'h02);

    // R7 transmitter write clears
    @(negedge clk_i); tx_wr_i = 1;
    @(negedge clk_i); tx_wr_i = 0;
    peek(1, d); check("R7 tx write clear", d, 8'h01);

    // R7 clear wins over set
    tx_below_i = 0;
    @(negedge clk_i); tx_below_i = 1; tx_wr_i = 1;
    @(negedge clk_i); tx_wr_i = 0;
    peek(1, d); check("R7 clear beats set", d, 8'h01);

    // R6 mirror of FIFO enable
    fifo_en_i = 1; rx_err_i = 1; wr_ie(8'h04);
    peek(1, d); check("R6 mirror", d, 8'hC6);
    rx_err_i = 0; #1;
    peek(1, d); check("R6 R9 idle mirror", d, 8'hC1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule